// File: doc/BRIEF.md
# Debounced Wake-Up Controller

This block gathers every reason to power the core back up and turns them into one wake-up request. There are sixteen general wake-up pins, one active-low force pin, and two alarm lines, one from a timer and one from a calendar clock. The whole block runs on the always-on slow clock. Each general pin has an enable bit and a bit that picks its active level. The pins share one debounce counter and one debounce-length code. The force pin has its own enable, its own counter and its own code.

When a source has been active for the required time, the block raises `wake_req` for one slow-clock cycle. It also records which class of source caused the wake-up in flags that stay set until a status read. For the general pins it keeps a 16-bit picture of which enabled pins were active at the moment the counter fired. Both pin groups pass through a two-flop synchroniser before any logic sees them.

Top module: `wk_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, `wake_req`, `force_cause`, `input_cause` and `snapshot` are 0, and `force_level` is 1.
- R2: A 3-bit debounce code selects the hold length L. Code 1 gives 3 cycles, code 2 gives 32, code 3 gives 512, code 4 gives 4096 and code 5 gives 32768. Codes 0, 6 and 7 give L = 1. An input change that is in place before a rising edge produces `wake_req` high after the (L+2)-th rising edge, counting that edge as the first.
- R3: A general pin whose `wk_en` bit is 0 never contributes to a wake-up or to `snapshot`. With `wk_en` all zero, no general wake-up occurs.
- R4: `wk_pol` bit 1 makes a pin active when high. Bit 0 makes it active when low.
- R5: The force pin is active when `force_n` is 0 and `force_en` is 1. Its hold length comes from `force_code`, independently of `wk_code`. A completed force debounce sets `force_cause`.
- R6: A rising edge of (`tmr_alarm` and `tmr_en`) or of (`cal_alarm` and `cal_en`) raises `wake_req` after the next rising edge. With the enable at 0, the alarm has no effect.
- R7: `force_cause` and `input_cause` stay set until `stat_rd` is sampled high, which clears them. A new cause in the same cycle as the read wins over the clear.
- R8: When the general debounce completes, `snapshot` takes the value `wk_en` AND (the set of pins at their active level), and `input_cause` is set.
- R9: `wake_req` is a single-cycle pulse. A source that stays active does not fire again until it has gone inactive and been debounced once more.
- R10: The shared general counter runs while any enabled pin is active. It restarts from zero as soon as no enabled pin is active, so an interrupted hold must be held again for the full length.
- R11: `force_level` shows the synchronised level of `force_n` two rising edges after the pin changes, whatever the state of `force_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous reset, active high |
| wk_in | input | 16 | General wake-up pins |
| wk_en | input | 16 | Per-pin enable |
| wk_pol | input | 16 | Per-pin active level (1 = high) |
| wk_code | input | 3 | Debounce code shared by the general pins |
| force_n | input | 1 | Force pin, active low |
| force_en | input | 1 | Force pin enable |
| force_code | input | 3 | Debounce code for the force pin |
| tmr_alarm | input | 1 | Timer alarm line |
| tmr_en | input | 1 | Timer alarm enable |
| cal_alarm | input | 1 | Calendar alarm line |
| cal_en | input | 1 | Calendar alarm enable |
| stat_rd | input | 1 | Status read strobe; clears the cause flags |
| wake_req | output | 1 | One-cycle wake-up request |
| force_cause | output | 1 | Sticky: the force pin caused a wake-up |
| input_cause | output | 1 | Sticky: a general pin caused a wake-up |
| snapshot | output | 16 | Enabled, active pins at the last general wake-up |
| force_level | output | 1 | Synchronised level of the force pin |

## Verification
The assertions check on every cycle that a debouncer never fires on two consecutive cycles and that no general wake-up happens while every enable is clear. They also check that the cause flags hold until a read and that a newly raised general cause always comes with a non-empty snapshot. The exact hold lengths for each code, the polarity handling and the restart of the counter after an interrupted hold cannot be seen from a single cycle. The same is true of the alarm edge behaviour and the two-edge pin latency. Only the bench's timed scenarios, which count the edges up to the pulse, can show these.

// File: rtl/wk_pkg.sv
package wk_pkg;
    localparam int CODE_W = 3;
    localparam int CNT_W  = 16;
    localparam int N_IN   = 16;

    typedef logic [CODE_W-1:0] dbc_code_t;
    typedef logic [CNT_W-1:0]  dbc_cnt_t;

    typedef struct packed {
        logic force_hit;
        logic gen_hit;
        logic alarm_hit;
    } wake_src_t;

    // Required hold length in slow-clock cycles for a debounce code.
    function automatic dbc_cnt_t dbc_len(dbc_code_t code);
        case (code)
            3'd1:    return dbc_cnt_t'(3);
            3'd2:    return dbc_cnt_t'(32);
            3'd3:    return dbc_cnt_t'(512);
            3'd4:    return dbc_cnt_t'(4096);
            3'd5:    return dbc_cnt_t'(32768);
            default: return dbc_cnt_t'(1);
        endcase
    endfunction
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/wk_debounce.sv
module wk_debounce
    import wk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  dbc_code_t code,
    output logic      fire
);
    dbc_cnt_t cnt;
    dbc_cnt_t len_m1;
    logic     done;

    assign len_m1 = dbc_len(code) - dbc_cnt_t'(1);
    // Fires on the L-th consecutive active cycle, once per active episode.
    assign fire   = active && !done && (cnt >= len_m1);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (fire) begin
            done <= 1'b1;
        end else if (!done) begin
            cnt <= cnt + dbc_cnt_t'(1);
        end
    end
endmodule

// File: rtl/wk_ctrl.sv
module wk_ctrl
    import wk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IN-1:0]   wk_in,
    input  logic [N_IN-1:0]   wk_en,
    input  logic [N_IN-1:0]   wk_pol,
    input  logic [CODE_W-1:0] wk_code,
    input  logic              force_n,
    input  logic              force_en,
    input  logic [CODE_W-1:0] force_code,
    input  logic              tmr_alarm,
    input  logic              tmr_en,
    input  logic              cal_alarm,
    input  logic              cal_en,
    input  logic              stat_rd,
    output logic              wake_req,
    output logic              force_cause,
    output logic              input_cause,
    output logic [N_IN-1:0]   snapshot,
    output logic              force_level
);
    logic [N_IN-1:0] wk_sync_q;
    logic [N_IN-1:0] act_vec;
    logic            force_sync_q;
    logic            gen_active;
    logic            force_active;
    logic            gen_fire;
    logic            force_fire;
    logic            alarm_now;
    logic            alarm_q;
    wake_src_t       src;

    wk_sync #(.W(N_IN), .RST_VAL('0)) i_sync_wk (
        .clk(clk), .rst(rst), .d(wk_in), .q(wk_sync_q)
    );

    wk_sync #(.W(1), .RST_VAL(1'b1)) i_sync_force (
        .clk(clk), .rst(rst), .d(force_n), .q(force_sync_q)
    );

    // Per-pin qualification: enabled and at its selected active level.
    for (genvar i = 0; i < N_IN; i++) begin : g_qual
        assign act_vec[i] = wk_en[i] & ~(wk_sync_q[i] ^ wk_pol[i]);
    end

    assign gen_active   = |act_vec;
    assign force_active = force_en & ~force_sync_q;

    wk_debounce i_dbc_gen (
        .clk(clk), .rst(rst), .active(gen_active), .code(dbc_code_t'(wk_code)), .fire(gen_fire)
    );

    wk_debounce i_dbc_force (
        .clk(clk), .rst(rst), .active(force_active), .code(dbc_code_t'(force_code)), .fire(force_fire)
    );

    assign alarm_now = (tmr_alarm & tmr_en) | (cal_alarm & cal_en);

    always_comb begin
        src.force_hit = force_fire;
        src.gen_hit   = gen_fire;
        src.alarm_hit = alarm_now & ~alarm_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q     <= 1'b0;
            wake_req    <= 1'b0;
            force_cause <= 1'b0;
            input_cause <= 1'b0;
            snapshot    <= '0;
        end else begin
            alarm_q  <= alarm_now;
            wake_req <= |src;
            if (src.force_hit)  force_cause <= 1'b1;
            else if (stat_rd)   force_cause <= 1'b0;
            if (src.gen_hit)    input_cause <= 1'b1;
            else if (stat_rd)   input_cause <= 1'b0;
            if (src.gen_hit)    snapshot <= act_vec;
        end
    end

    assign force_level = force_sync_q;
endmodule

// File: rtl/wk_ctrl_chk.sv
module wk_ctrl_chk
    import wk_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [N_IN-1:0] wk_en,
    input logic            stat_rd,
    input logic            force_cause,
    input logic            input_cause,
    input logic [N_IN-1:0] snapshot,
    input logic            gen_fire,
    input logic            force_fire
);
    AST_GEN_NO_REFIRE: assert property (@(posedge clk) disable iff (rst)
        gen_fire |=> !gen_fire); // R9
    AST_FORCE_NO_REFIRE: assert property (@(posedge clk) disable iff (rst)
        force_fire |=> !force_fire); // R9
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (wk_en == '0) |-> !gen_fire); // R3
    AST_INPUT_CAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (input_cause && !stat_rd) |=> input_cause); // R7
    AST_FORCE_CAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (force_cause && !stat_rd) |=> force_cause); // R7
    AST_SNAP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        $rose(input_cause) |-> (snapshot != '0)); // R8
endmodule

bind wk_ctrl wk_ctrl_chk i_chk (
    .clk(clk), .rst(rst), .wk_en(wk_en), .stat_rd(stat_rd),
    .force_cause(force_cause), .input_cause(input_cause), .snapshot(snapshot),
    .gen_fire(gen_fire), .force_fire(force_fire)
);

// File: tb/test_wk_ctrl.sv
module test_wk_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] wk_in = '0, wk_en = '0, wk_pol = '0;
    logic [2:0]  wk_code = '0, force_code = '0;
    logic        force_n = 1'b1, force_en = 1'b0;
    logic        tmr_alarm = 1'b0, tmr_en = 1'b0, cal_alarm = 1'b0, cal_en = 1'b0;
    logic        stat_rd = 1'b0;
    logic        wake_req, force_cause, input_cause, force_level;
    logic [15:0] snapshot;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    wk_ctrl i_wk_ctrl (
        .clk(clk), .rst(rst), .wk_in(wk_in), .wk_en(wk_en), .wk_pol(wk_pol),
        .wk_code(wk_code), .force_n(force_n), .force_en(force_en),
        .force_code(force_code), .tmr_alarm(tmr_alarm), .tmr_en(tmr_en),
        .cal_alarm(cal_alarm), .cal_en(cal_en), .stat_rd(stat_rd),
        .wake_req(wake_req), .force_cause(force_cause), .input_cause(input_cause),
        .snapshot(snapshot), .force_level(force_level)
    );

    always #4 clk = ~clk;

    function automatic int exp_len(logic [2:0] c);
        case (c)
            3'd1: return 3;
            3'd2: return 32;
            3'd3: return 512;
            3'd4: return 4096;
            3'd5: return 32768;
            default: return 1;
        endcase
    endfunction

    function automatic logic [15:0] exp_snap(logic [15:0] en, logic [15:0] active_mask);
        return en & active_mask;
    endfunction

    function automatic logic [15:0] drive_level(logic [15:0] pol, logic [15:0] active_mask);
        return (pol & active_mask) | (~pol & ~active_mask);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic measure(input int maxc, output bit found, output int lat);
        found = 1'b0;
        lat   = 0;
        for (int i = 1; i <= maxc; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (wake_req) begin
                found = 1'b1;
                lat   = i;
                break;
            end
        end
    endtask

    task automatic read_status();
        stat_rd = 1'b1;
        step(1);
        stat_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
                finish_run();
            end
        end
    end

    initial begin
        bit          found;
        int          lat;
        int          seed_dummy;
        logic [2:0]  codes [5];
        codes[0] = 3'd0; codes[1] = 3'd1; codes[2] = 3'd2; codes[3] = 3'd6; codes[4] = 3'd7;
        seed_dummy = $urandom(32'd20240611);

        @(negedge clk);
        step(3);
        // R1: outputs during reset
        chk(wake_req == 0 && force_cause == 0 && input_cause == 0 && snapshot == 0,
            "R1", "outputs in reset", {wake_req, force_cause, input_cause}, 0);
        chk(force_level == 1, "R1", "force_level in reset", force_level, 1);
        rst = 1'b0;
        step(1);
        chk(wake_req == 0 && snapshot == 0, "R1", "first cycle after reset", snapshot, 0);

        // Random general-pin trials (R2, R3, R4, R7, R8)
        for (int t = 0; t < 24; t++) begin
            logic [15:0] en, pol, m, es;
            logic [2:0]  cd;
            int          len;
            en  = 16'($urandom);
            pol = 16'($urandom);
            m   = 16'($urandom);
            if (t % 6 == 5) m = ~en;   // only disabled pins go active
            cd  = codes[$urandom % 5];
            len = exp_len(cd);
            es  = exp_snap(en, m);
            wk_en   = '0;
            wk_pol  = pol;
            wk_code = cd;
            wk_in   = drive_level(pol, '0);
            step(4);
            wk_en = en;
            read_status();
            chk(input_cause == 0, "R7", "input_cause after read", input_cause, 0);
            wk_in = drive_level(pol, m);
            measure(len + 6, found, lat);
            if (es != 0) begin
                chk(found && lat == len + 2, "R2", "general latency", lat, len + 2);
                chk(snapshot == es, "R8", "snapshot", snapshot, es);
                chk(input_cause == 1, "R8", "input_cause set", input_cause, 1);
                step(1);
                chk(wake_req == 0, "R9", "pulse width", wake_req, 0);
            end else begin
                chk(!found, "R3", "disabled pins silent", found, 0);
                chk(input_cause == 0, "R3", "no cause from disabled pins", input_cause, 0);
            end
            wk_in = drive_level(pol, '0);
            step(4);
        end

        // R4: explicit polarity, pin 3 active low, pin 4 active high
        wk_en = '0; wk_code = 3'd0;
        wk_pol = 16'h0010; wk_in = 16'h0008;
        step(4);
        wk_en = 16'h0018;
        read_status();
        wk_in = 16'h0010;  // pin 3 low (active), pin 4 high (active)
        measure(6, found, lat);
        chk(found && lat == 3, "R4", "polarity latency", lat, 3);
        chk(snapshot == 16'h0018, "R4", "polarity snapshot", snapshot, 16'h0018);

        // R9: held input does not refire; refires after release
        measure(100, found, lat);
        chk(!found, "R9", "no refire while held", found, 0);
        wk_in = 16'h0008;
        step(4);
        wk_in = 16'h0010;
        measure(6, found, lat);
        chk(found && lat == 3, "R9", "refire after release", lat, 3);
        wk_in = 16'h0008;
        step(4);

        // R10: interrupted hold restarts the shared counter
        wk_en = '0; wk_pol = 16'h0001; wk_in = 16'h0000; wk_code = 3'd2;
        step(4);
        wk_en = 16'h0001;
        wk_in = 16'h0001;
        measure(20, found, lat);
        chk(!found, "R10", "no fire before full hold", found, 0);
        wk_in = 16'h0000;
        step(3);
        wk_in = 16'h0001;
        measure(40, found, lat);
        chk(found && lat == 34, "R10", "latency after restart", lat, 34);
        wk_in = 16'h0000;
        step(4);

        // R2: long general code 5
        wk_code = 3'd5;
        read_status();
        wk_in = 16'h0001;
        measure(32780, found, lat);
        chk(found && lat == 32770, "R2", "code 5 latency", lat, 32770);
        wk_in = 16'h0000;
        wk_en = '0;
        step(4);

        // R5 and R11: force pin
        force_en = 1'b0; force_code = 3'd1;
        read_status();
        force_n = 1'b0;
        step(2);
        chk(force_level == 0, "R11", "force_level follows pin", force_level, 0);
        measure(10, found, lat);
        chk(!found && force_cause == 0, "R5", "disabled force pin silent", found, 0);
        force_n = 1'b1;
        step(4);
        force_en = 1'b1;
        force_n  = 1'b0;
        measure(10, found, lat);
        chk(found && lat == 5, "R5", "force latency code 1", lat, 5);
        chk(force_cause == 1 && input_cause == 0, "R5", "force cause only",
            {force_cause, input_cause}, 2);
        step(3);
        chk(force_cause == 1, "R7", "force_cause held", force_cause, 1);
        read_status();
        chk(force_cause == 0, "R7", "force_cause cleared", force_cause, 0);
        force_n = 1'b1;
        step(4);
        force_code = 3'd4; wk_code = 3'd0;
        force_n = 1'b0;
        measure(4110, found, lat);
        chk(found && lat == 4098, "R5", "force code 4 independent of wk_code", lat, 4098);
        force_n = 1'b1; force_en = 1'b0;
        step(4);

        // R6: alarms
        tmr_en = 1'b0; tmr_alarm = 1'b1;
        measure(5, found, lat);
        chk(!found, "R6", "timer alarm disabled", found, 0);
        tmr_alarm = 1'b0; tmr_en = 1'b1;
        step(2);
        tmr_alarm = 1'b1;
        measure(5, found, lat);
        chk(found && lat == 1, "R6", "timer alarm latency", lat, 1);
        measure(10, found, lat);
        chk(!found, "R6", "held timer alarm single pulse", found, 0);
        tmr_alarm = 1'b0; tmr_en = 1'b0;
        cal_en = 1'b1;
        step(2);
        cal_alarm = 1'b1;
        measure(5, found, lat);
        chk(found && lat == 1, "R6", "calendar alarm latency", lat, 1);
        cal_alarm = 1'b0;
        step(2);

        finish_run();
    end
endmodule